// File: doc/BRIEF.md
# Predicate Register File with Complementary Pair Writes

This block stores a bank of one-bit guard flags that decide whether issued operations take effect. A compare unit elsewhere in the pipeline produces a one-bit outcome and names two destination flags. In a single clock the outcome is written to the first destination and its inverse to the second. The two arms of a former branch can then issue side by side, each under one of the two opposite guards.

Several issue lanes each name a guard flag and present an operation-valid bit. The block returns the guard value for each lane and a fire bit that is low whenever the guard is false, so a squashed operation changes no state. Flag 0 is wired to true, so it serves as the "always execute" guard. If a compare names the same flag as both of its destinations, nothing is written and a clash flag is raised in the next cycle. A lane that reads a flag in the same cycle as it is written sees the new value.

Top module: `pred_regfile`

## Requirements
- R1: When reset is released, every flag reads 0 except flag 0, which reads 1.
- R2: Flag 0 reads 1 at all times. A compare whose destination is flag 0 leaves it unchanged, and the other destination of that compare is still written.
- R3: With `cmp_en` high and two distinct destinations, after the clock edge the true destination holds `cmp_res` and the false destination holds its inverse.
- R4: With `cmp_en` high and `cmp_dst_t == cmp_dst_f`, no flag changes and `cmp_clash` is 1 in the following cycle. In every other case `cmp_clash` is 0 in the following cycle.
- R5: A lane reading a flag that a valid pair write targets in the same cycle returns the value being written.
- R6: Each lane `i` selects its flag with `rd_sel[i*IW +: IW]` (where IW = clog2(NUM_PREDS)) and returns it on `guard[i]`, independently of the other lanes.
- R7: `op_fire[i]` equals `op_valid[i] & guard[i]`, so an operation with a false guard never fires.
- R8: Flags that are not named by a valid write keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_en | input | 1 | Compare outcome is valid this cycle |
| cmp_dst_t | input | IW | Flag that receives the outcome |
| cmp_dst_f | input | IW | Flag that receives the inverted outcome |
| cmp_res | input | 1 | Compare outcome |
| rd_sel | input | NUM_RD*IW | Guard flag index for each lane |
| op_valid | input | NUM_RD | Operation presented on each lane |
| guard | output | NUM_RD | Guard value for each lane |
| op_fire | output | NUM_RD | Operation is allowed to take effect |
| cmp_clash | output | 1 | Previous compare named one flag twice |

## Verification
The bench builds the block with 16 flags and three lanes. With this small bank, random compare traffic hits every flag, flag 0 and same-destination clashes many times, and it often lands on a flag that a lane reads in the same cycle. Directed steps before the random phase read out the whole reset state and isolate each of these cases.

// File: rtl/pred_regfile.sv
module pred_regfile #(
  parameter int NUM_PREDS = 64,
  parameter int NUM_RD    = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cmp_en,
  input  logic [$clog2(NUM_PREDS)-1:0]          cmp_dst_t,
  input  logic [$clog2(NUM_PREDS)-1:0]          cmp_dst_f,
  input  logic                                  cmp_res,
  input  logic [NUM_RD*$clog2(NUM_PREDS)-1:0]   rd_sel,
  input  logic [NUM_RD-1:0]                     op_valid,
  output logic [NUM_RD-1:0]                     guard,
  output logic [NUM_RD-1:0]                     op_fire,
  output logic                                  cmp_clash
);
  localparam int IW = $clog2(NUM_PREDS);

  logic [NUM_PREDS-1:0] pr_q;
  logic                 wr_ok;

  assign wr_ok = cmp_en && (cmp_dst_t != cmp_dst_f);
  assign pr_q[0] = 1'b1;

  for (genvar g = 1; g < NUM_PREDS; g++) begin : g_flag
    logic hit_t, hit_f;
    assign hit_t = wr_ok && (cmp_dst_t == IW'(g));
    assign hit_f = wr_ok && (cmp_dst_f == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)     pr_q[g] <= 1'b0;
      else if (hit_t) pr_q[g] <= cmp_res;
      else if (hit_f) pr_q[g] <= ~cmp_res;
    end
  end

  for (genvar i = 0; i < NUM_RD; i++) begin : g_lane
    logic [IW-1:0] idx;
    assign idx = rd_sel[i*IW +: IW];
    always_comb begin
      guard[i] = pr_q[idx];
      if (wr_ok && idx != '0) begin
        if (idx == cmp_dst_t)      guard[i] = cmp_res;
        else if (idx == cmp_dst_f) guard[i] = ~cmp_res;
      end
    end
    assign op_fire[i] = op_valid[i] & guard[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_clash <= 1'b0;
    else        cmp_clash <= cmp_en && (cmp_dst_t == cmp_dst_f);
  end
endmodule

// File: rtl/pred_regfile_chk.sv
module pred_regfile_chk #(
  parameter int NUM_PREDS = 64,
  parameter int NUM_RD    = 3
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                cmp_en,
  input logic [$clog2(NUM_PREDS)-1:0]        cmp_dst_t,
  input logic [$clog2(NUM_PREDS)-1:0]        cmp_dst_f,
  input logic                                cmp_res,
  input logic [NUM_RD*$clog2(NUM_PREDS)-1:0] rd_sel,
  input logic [NUM_RD-1:0]                   op_valid,
  input logic [NUM_RD-1:0]                   guard,
  input logic [NUM_RD-1:0]                   op_fire,
  input logic                                cmp_clash
);
  localparam int IW = $clog2(NUM_PREDS);

  AST_CLASH_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cmp_dst_t == cmp_dst_f) |=> cmp_clash); // R4
  AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_en && cmp_dst_t == cmp_dst_f) |=> !cmp_clash); // R4

  for (genvar i = 0; i < NUM_RD; i++) begin : g_lane
    logic [IW-1:0] sel;
    assign sel = rd_sel[i*IW +: IW];

    AST_ZERO_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> guard[i]); // R2
    AST_NO_FIRE_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
      !guard[i] |-> !op_fire[i]); // R7
    AST_BYPASS_T: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && cmp_dst_t != cmp_dst_f && cmp_dst_t != '0 && sel == cmp_dst_t)
      |-> (guard[i] == cmp_res)); // R5
    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmp_en) && $past(cmp_dst_t) != $past(cmp_dst_f) && $past(cmp_dst_t) != '0
       && sel == $past(cmp_dst_t)
       && !(cmp_en && cmp_dst_t != cmp_dst_f && (cmp_dst_t == sel || cmp_dst_f == sel)))
      |-> (guard[i] == $past(cmp_res))); // R3
  end
endmodule

bind pred_regfile pred_regfile_chk #(.NUM_PREDS(NUM_PREDS), .NUM_RD(NUM_RD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_dst_t(cmp_dst_t),
  .cmp_dst_f(cmp_dst_f), .cmp_res(cmp_res), .rd_sel(rd_sel),
  .op_valid(op_valid), .guard(guard), .op_fire(op_fire), .cmp_clash(cmp_clash)
);

// File: tb/pred_regfile_tb.sv
`timescale 1ns/1ps
module pred_regfile_tb;
  localparam int NP = 16;
  localparam int NR = 3;
  localparam int IW = $clog2(NP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_en = 1'b0;
  logic [IW-1:0]     cmp_dst_t = '0;
  logic [IW-1:0]     cmp_dst_f = '0;
  logic              cmp_res = 1'b0;
  logic [NR*IW-1:0]  rd_sel = '0;
  logic [NR-1:0]     op_valid = '0;
  logic [NR-1:0]     guard;
  logic [NR-1:0]     op_fire;
  logic              cmp_clash;

  always #2 clk = ~clk;

  pred_regfile #(.NUM_PREDS(NP), .NUM_RD(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_dst_t(cmp_dst_t),
    .cmp_dst_f(cmp_dst_f), .cmp_res(cmp_res), .rd_sel(rd_sel),
    .op_valid(op_valid), .guard(guard), .op_fire(op_fire), .cmp_clash(cmp_clash)
  );

  typedef struct {
    logic [NR-1:0] g;
    logic [NR-1:0] f;
    logic          c;
    string         tag;
  } exp_t;

  exp_t  sb[$];
  event  ev_push;
  int    n_chk = 0;
  int    n_fail = 0;
  logic  mdl [NP];
  logic  mdl_clash;

  function automatic logic exp_read(input logic [IW-1:0] idx);
    if (idx == '0) return 1'b1;
    if (cmp_en && cmp_dst_t != cmp_dst_f) begin
      if (idx == cmp_dst_t) return cmp_res;
      if (idx == cmp_dst_f) return ~cmp_res;
    end
    return mdl[idx];
  endfunction

  task automatic cyc(input logic en, input int t, input int f, input logic res,
                     input int s0, input int s1, input int s2,
                     input logic [NR-1:0] vld, input string tag);
    exp_t e;
    @(negedge clk);
    cmp_en = en; cmp_dst_t = IW'(t); cmp_dst_f = IW'(f); cmp_res = res;
    rd_sel = {IW'(s2), IW'(s1), IW'(s0)};
    op_valid = vld;
    for (int i = 0; i < NR; i++) e.g[i] = exp_read(rd_sel[i*IW +: IW]);
    e.f = vld & e.g;
    e.c = mdl_clash;
    e.tag = tag;
    sb.push_back(e);
    ->ev_push;
    @(posedge clk);
    if (en && t != f) begin
      if (t != 0) mdl[t] = res;
      if (f != 0) mdl[f] = ~res;
    end
    mdl_clash = en && (t == f);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      @(ev_push);
      #1;
      e = sb.pop_front();
      for (int i = 0; i < NR; i++) begin
        n_chk++;
        if (guard[i] !== e.g[i]) begin
          n_fail++;
          $display("FAIL %s lane %0d guard actual=%b expected=%b", e.tag, i, guard[i], e.g[i]);
        end
      end
      n_chk++;
      if (op_fire !== e.f) begin
        n_fail++;
        $display("FAIL R7 op_fire actual=%b expected=%b", op_fire, e.f);
      end
      n_chk++;
      if (cmp_clash !== e.c) begin
        n_fail++;
        $display("FAIL R4 cmp_clash actual=%b expected=%b", cmp_clash, e.c);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    for (int k = 0; k < NP; k++) mdl[k] = 1'b0;
    mdl[0] = 1'b1;
    mdl_clash = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every flag
    for (int k = 0; k < NP; k += 3)
      cyc(0, 0, 0, 0, k, (k + 1) % NP, (k + 2) % NP, 3'b111, "R1");

    // R3: pair write, then read back
    cyc(1, 3, 4, 1, 5, 6, 7, 3'b000, "R8");
    cyc(0, 0, 0, 0, 3, 4, 0, 3'b111, "R3");
    cyc(1, 3, 4, 0, 1, 2, 9, 3'b101, "R8");
    cyc(0, 0, 0, 0, 3, 4, 5, 3'b111, "R3");

    // R2: flag 0 as a destination
    cyc(1, 0, 7, 1, 0, 7, 8, 3'b111, "R2");
    cyc(0, 0, 0, 0, 0, 7, 0, 3'b111, "R2");
    cyc(1, 8, 0, 0, 0, 8, 0, 3'b011, "R2");
    cyc(0, 0, 0, 0, 8, 0, 7, 3'b111, "R2");

    // R4: same flag named twice
    cyc(1, 9, 9, 1, 9, 3, 4, 3'b111, "R4");
    cyc(0, 0, 0, 0, 9, 3, 4, 3'b111, "R4");
    cyc(1, 0, 0, 1, 0, 0, 0, 3'b111, "R4");
    cyc(0, 0, 0, 0, 0, 9, 1, 3'b111, "R4");

    // R5: same-cycle read of written flags
    cyc(1, 10, 11, 1, 10, 11, 12, 3'b111, "R5");
    cyc(1, 10, 11, 0, 11, 10, 10, 3'b111, "R5");
    cyc(0, 0, 0, 0, 10, 11, 12, 3'b111, "R8");

    // R6, R7: random traffic across all lanes
    for (int n = 0; n < 3000; n++)
      cyc(1'($urandom_range(0, 1)), $urandom_range(0, NP - 1), $urandom_range(0, NP - 1),
          1'($urandom_range(0, 1)), $urandom_range(0, NP - 1), $urandom_range(0, NP - 1),
          $urandom_range(0, NP - 1), NR'($urandom_range(0, 7)), "R6");

    // R1: reset applied mid-run clears the bank again
    @(negedge clk);
    rst_n = 1'b0;
    cmp_en = 1'b0;
    repeat (2) @(posedge clk);
    for (int k = 1; k < NP; k++) mdl[k] = 1'b0;
    mdl_clash = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NP; k += 3)
      cyc(0, 0, 0, 0, k, (k + 1) % NP, (k + 2) % NP, 3'b111, "R1");

    @(negedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule